// File: doc/BRIEF.md
# MDIO Management Controller

This block runs one Clause-22 management transaction at a time on the two-wire MDC/MDIO bus of an external PHY. Software programs a small register file. It loads the data register (for a write), then writes a command word that holds an opcode bit, a 5-bit PHY address and a 5-bit register address. The controller then serialises the whole frame by itself. A busy flag stays up while the frame is on the wire. When a read finishes, the data register holds the 16 bits that the PHY returned.

MDC is made from the system clock by a programmable divisor. The divisor field holds the period minus one. The 32-bit all-ones preamble can be dropped by a control bit when the PHY accepts short frames. A self-clearing soft-reset bit aborts any frame and restores the defaults.

The frame engine is a state machine with five states. IDLE leaves it on an accepted command: to PREAMBLE when the preamble is enabled, or straight to HEADER when it is suppressed. PREAMBLE goes to HEADER after its 32nd bit. HEADER shifts out start, opcode and both addresses, then moves to TURN after 14 bits. TURN moves to DATA after 2 bits. DATA returns to IDLE after 16 bits. Every state returns to IDLE at once on a soft reset. Each bit ends on a falling MDC edge, and all state moves happen there.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the data register reads 0, the status register reads 0, the control register reads 0x4E00 (divisor field 39, preamble bit 0, reset bit 0) and the command address reads 0. MDC is low and MDIO is not driven.
- R2: Register addresses are: 0 command, 1 data, 2 status, 3 control. In a command word, bit 15 requests a read and bit 14 requests a write, with the read winning if both are set. Bits 9:5 hold the PHY address and bits 4:0 the register address. A command word with neither bit 15 nor bit 14 set starts nothing.
- R3: Status bit 0 reads 1 from the clock after an accepted command write until the frame's last bit ends, and reads 0 otherwise.
- R4: A write frame is 32 ones, 01, 01, the PHY address, the register address, 10, then the 16 data bits. Every field goes out MSB first, one bit per MDC period, with MDIO driven throughout. MDIO never changes on the clock where MDC rises.
- R5: A read frame carries 01 and 10 after the preamble, then both addresses. MDIO is released for the last 18 bit slots (turnaround and data). The controller samples MDIO at each rising MDC edge of the data phase, and the 16 bits, MSB first, land in the data register when the frame ends.
- R6: The control register's bits 15:9 hold the MDC period minus one, counted in system clocks. The field is read once, when a command starts. A field value of 0 is treated as 1.
- R7: Control bit 8 set drops the preamble, so a frame is 32 bit slots long.
- R8: A command written while status bit 0 is 1 is ignored: the frame in flight is not changed and no second frame follows.
- R9: Writing control bit 0 as 1 makes bit 0 read 1 for exactly one clock (the other control fields in that write are ignored). In the next clock the controller aborts any frame, clears the data register and restores the control defaults.
- R10: Whenever status bit 0 is 0, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The hardest case to reach is a command that arrives while a read is in mid-flight. The bench must show that this command does not disturb the frame, does not queue a second frame, and does not corrupt the returned data. The read-data path is also hard to reach, because it needs a PHY that drives the line only after the controller lets go. The bench therefore includes a responder that watches MDC and the output enable. It drives a zero on the second turnaround slot and then a chosen word, changing the line on falling MDC edges. A second command is written about fifty clocks into that read. The bench then counts the MDC rising edges and checks the word in the data register.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;

    localparam int CMD_RD_BIT = 15;
    localparam int CMD_WR_BIT = 14;
    localparam int CMD_PHY_LSB = 5;
    localparam int CMD_REG_LSB = 0;
    localparam int CTRL_DIV_LSB = 9;
    localparam int CTRL_NOPRE_BIT = 8;
    localparam int CTRL_SRST_BIT = 0;

    localparam int PRE_BITS  = 32;
    localparam int TURN_BITS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_clk_div.sv
// MDC generator: period = lim+1 system clocks, first rising edge after a
// half period so the first bit has setup time before the PHY samples it.
module mdio_clk_div #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_new;

    // R6: a zero field behaves as one
    assign lim_new = (div_m1 == '0) ? ONE : div_m1;
    assign rise    = run && (cnt_q == lim_q);
    assign fall    = run && (cnt_q == (lim_q >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= ONE;
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (start) begin
            lim_q <= lim_new;
            cnt_q <= (lim_new >> 1) + ONE;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (rise) begin
            cnt_q <= '0;
            mdc   <= 1'b1;
        end else begin
            cnt_q <= cnt_q + ONE;
            if (fall) begin
                mdc <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame sequencer: every bit ends on a falling MDC pulse.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort,
    input  logic              op_rd,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REG_W-1:0]  regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              no_pre,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              is_rd,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int HDR_W = 4 + PHY_W + REG_W;
    localparam int MAXB  = (PRE_BITS > DATA_W) ? PRE_BITS : DATA_W;
    localparam int CNT_W = $clog2(MAXB);
    localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(PRE_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_TURN = CNT_W'(TURN_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_W - 1);

    mdio_state_e       state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [HDR_W-1:0]  hdr_q, hdr_n;
    logic [DATA_W-1:0] dat_q, dat_n;
    logic              rd_q, rd_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hdr_q   <= '0;
            dat_q   <= '0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            hdr_q   <= hdr_n;
            dat_q   <= dat_n;
            rd_q    <= rd_n;
        end
    end

    // next state and datapath
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        hdr_n   = hdr_q;
        dat_n   = dat_q;
        rd_n    = rd_q;
        done    = 1'b0;
        if (abort) begin
            state_n = ST_IDLE; // R9
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        rd_n  = op_rd;
                        hdr_n = {2'b01, (op_rd ? 2'b10 : 2'b01), phy, regad};
                        dat_n = wdata;
                        if (no_pre) begin // R7
                            state_n = ST_HEADER;
                            cnt_n   = CNT_HDR;
                        end else begin
                            state_n = ST_PREAMBLE;
                            cnt_n   = CNT_PRE;
                        end
                    end
                end
                ST_PREAMBLE: begin
                    if (fall) begin
                        if (cnt_q == '0) begin
                            state_n = ST_HEADER;
                            cnt_n   = CNT_HDR;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end
                end
                ST_HEADER: begin
                    if (fall) begin
                        hdr_n = hdr_q << 1;
                        if (cnt_q == '0) begin
                            state_n = ST_TURN;
                            cnt_n   = CNT_TURN;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end
                end
                ST_TURN: begin
                    if (fall) begin
                        if (cnt_q == '0) begin
                            state_n = ST_DATA;
                            cnt_n   = CNT_DATA;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (rise && rd_q) begin
                        dat_n = {dat_q[DATA_W-2:0], mdio_i}; // R5 sample on rising MDC
                    end
                    if (fall) begin
                        if (!rd_q) begin
                            dat_n = dat_q << 1;
                        end
                        if (cnt_q == '0) begin
                            state_n = ST_IDLE;
                            done    = 1'b1;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HEADER: begin
                mdio_o  = hdr_q[HDR_W-1];
                mdio_oe = 1'b1;
            end
            ST_TURN: begin
                mdio_oe = !rd_q;
                mdio_o  = !rd_q && (cnt_q == CNT_TURN);
            end
            ST_DATA: begin
                mdio_oe = !rd_q;
                mdio_o  = !rd_q && dat_q[DATA_W-1];
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign is_rd = rd_q;
    assign rdata = dat_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W     = 7,
    parameter int DIV_RESET = 39,
    parameter int PHY_W     = 5,
    parameter int REG_W     = 5,
    parameter int DATA_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

    logic [DATA_W-1:0] data_q;
    logic [DIV_W-1:0]  div_q;
    logic              nopre_q;
    logic              srst_q;
    logic              cmd_go;
    logic              eng_busy;
    logic              eng_rd;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              mdc_rise;
    logic              mdc_fall;
    logic [31:0]       ctrl_rd;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[31:16];

    // R2 / R8: accepted only when idle and not in soft reset
    assign cmd_go = reg_we && (reg_addr == A_CMD)
                    && (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT])
                    && !eng_busy && !srst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            div_q   <= DIV_INIT;
            nopre_q <= 1'b0;
            srst_q  <= 1'b0;
        end else if (srst_q) begin // R9
            data_q  <= '0;
            div_q   <= DIV_INIT;
            nopre_q <= 1'b0;
            srst_q  <= 1'b0;
        end else begin
            if (reg_we && reg_addr == A_DATA) begin
                data_q <= reg_wdata[DATA_W-1:0];
            end
            if (eng_done && eng_rd) begin
                data_q <= eng_rdata;
            end
            if (reg_we && reg_addr == A_CTRL) begin
                if (reg_wdata[CTRL_SRST_BIT]) begin
                    srst_q <= 1'b1;
                end else begin
                    div_q   <= reg_wdata[CTRL_DIV_LSB +: DIV_W];
                    nopre_q <= reg_wdata[CTRL_NOPRE_BIT];
                end
            end
        end
    end

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTRL_DIV_LSB +: DIV_W] = div_q;
        ctrl_rd[CTRL_NOPRE_BIT] = nopre_q;
        ctrl_rd[CTRL_SRST_BIT]  = srst_q;
    end

    always_comb begin
        case (reg_addr)
            A_DATA:  reg_rdata = {{(32-DATA_W){1'b0}}, data_q};
            A_STAT:  reg_rdata = {31'd0, eng_busy};
            A_CTRL:  reg_rdata = ctrl_rd;
            default: reg_rdata = '0;
        endcase
    end

    mdio_clk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cmd_go),
        .run    (eng_busy && !srst_q),
        .div_m1 (div_q),
        .mdc    (mdc),
        .rise   (mdc_rise),
        .fall   (mdc_fall)
    );

    mdio_frame_engine #(
        .PHY_W  (PHY_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (cmd_go),
        .abort   (srst_q),
        .op_rd   (reg_wdata[CMD_RD_BIT]),
        .phy     (reg_wdata[CMD_PHY_LSB +: PHY_W]),
        .regad   (reg_wdata[CMD_REG_LSB +: REG_W]),
        .wdata   (data_q),
        .no_pre  (nopre_q),
        .rise    (mdc_rise),
        .fall    (mdc_fall),
        .mdio_i  (mdio_i),
        .busy    (eng_busy),
        .is_rd   (eng_rd),
        .done    (eng_done),
        .rdata   (eng_rdata),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_req,
    input logic busy,
    input logic srst,
    input logic done,
    input logic is_rd,
    input logic rise,
    input logic fall,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    a_r3_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !busy && !srst |=> busy);

    a_r3_busy_ends_cleanly: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || srst));

    a_r4_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !is_rd |-> mdio_oe);

    a_r4_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o));

    a_r5_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
        busy && is_rd && !mdio_oe |=> !mdio_oe);

    a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

    a_r8_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(is_rd));

    a_r9_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !srst && !busy);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe && !mdc);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_req (reg_we && (reg_addr == mdio_mgmt_pkg::A_CMD)
              && (reg_wdata[15] || reg_wdata[14])),
    .busy    (eng_busy),
    .srst    (srst_q),
    .done    (eng_done),
    .is_rd   (eng_rd),
    .rise    (mdc_rise),
    .fall    (mdc_fall),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
    localparam int CLK_P = 10;
    localparam logic [1:0] AC = 2'd0, AD = 2'd1, AS = 2'd2, AK = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    wire  [31:0] reg_rdata;
    wire         mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #(CLK_P/2) clk = ~clk;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int total = 0;
    int bad = 0;
    logic [15:0] resp = 16'h1234;

    // bus monitor and PHY responder, sampled away from the active edge
    int cyc = 0, nrise = 0, last_rise = 0, per = 0, phy_idx = 0;
    logic mdc_prev = 1'b0;
    logic [63:0] capv = 64'd0, capo = 64'd0;
    always @(negedge clk) begin
        cyc++;
        if (mdc && !mdc_prev) begin
            per = cyc - last_rise;
            last_rise = cyc;
            nrise++;
            capv = {capv[62:0], mdio_o};
            capo = {capo[62:0], mdio_oe};
        end
        if (!mdio_oe) begin
            if (!mdc && mdc_prev) begin
                phy_idx++;
                if (phy_idx == 2) mdio_i = 1'b0;
                else if (phy_idx >= 3 && phy_idx <= 18) mdio_i = resp[18 - phy_idx];
                else mdio_i = 1'b1;
            end
        end else begin
            phy_idx = 0;
            mdio_i = 1'b1;
        end
        mdc_prev = mdc;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        rd(AS, v);
        while (v[0] && n < 5000) begin
            @(negedge clk);
            n++;
            rd(AS, v);
        end
        check(req, {63'd0, v[0]}, 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(AS, v); check("R1 status", v, 0);
        rd(AK, v); check("R1 control", v, 32'h4E00);
        rd(AD, v); check("R1 data", v, 0);
        rd(AC, v); check("R1 command readback", v, 0);
        check("R1 mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_write_pre();
        logic [31:0] v;
        int n0;
        wr(AK, 32'd3 << 9);
        wr(AD, 32'hA5C3);
        n0 = nrise;
        wr(AC, (32'd1 << 14) | (32'd5 << 5) | 32'd17);
        rd(AS, v); check("R3 busy after command", v, 1);
        wait_idle("R3 busy clears");
        check("R4 bit count", nrise - n0, 64);
        check("R4 frame bits", capv,
              {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd17, 2'b10, 16'hA5C3});
        check("R4 driven throughout", capo, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R6 period divisor 4", per, 4);
        check("R10 idle mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        int n0;
        resp = 16'h1234;
        n0 = nrise;
        wr(AC, (32'd1 << 15) | (32'd3 << 5) | 32'd2);
        wait_idle("R3 read busy clears");
        check("R5 bit count", nrise - n0, 64);
        check("R5 header", capv[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd2});
        check("R5 release pattern", capo, ~64'h3FFFF);
        rd(AD, v); check("R5 read data", v, 32'h1234);
    endtask

    task automatic t_nopre();
        logic [31:0] v;
        int n0;
        wr(AK, (32'd4 << 9) | (32'd1 << 8));
        rd(AK, v); check("R6 control field readback", v, (32'd4 << 9) | (32'd1 << 8));
        wr(AD, 32'h0F0F);
        n0 = nrise;
        wr(AC, (32'd1 << 14) | (32'd31 << 5));
        wait_idle("R7 busy clears");
        check("R7 bit count", nrise - n0, 32);
        check("R7 frame bits", capv[31:0], {2'b01, 2'b01, 5'd31, 5'd0, 2'b10, 16'h0F0F});
        check("R6 period divisor 5", per, 5);
    endtask

    task automatic t_div0();
        wr(AK, 32'd1 << 8);
        wr(AC, (32'd1 << 14) | 32'd1);
        wait_idle("R6 zero field busy clears");
        check("R6 zero field period", per, 2);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int n0;
        wr(AK, 32'd3 << 9);
        resp = 16'hBEEF;
        n0 = nrise;
        wr(AC, 32'hC000 | (32'd9 << 5) | 32'd4);
        repeat (50) @(negedge clk);
        wr(AC, (32'd1 << 14) | (32'd1 << 5) | 32'd1);
        wait_idle("R8 busy clears");
        check("R8 single frame", nrise - n0, 64);
        check("R2 both bits read wins", capo, ~64'h3FFFF);
        check("R2 header opcode", capv[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd9, 5'd4});
        rd(AD, v); check("R8 read data intact", v, 32'hBEEF);
        repeat (300) @(negedge clk);
        rd(AS, v); check("R8 no queued frame busy", v, 0);
        check("R8 no queued frame edges", nrise - n0, 64);
    endtask

    task automatic t_noop();
        logic [31:0] v;
        int n0;
        n0 = nrise;
        wr(AC, (32'd2 << 5) | 32'd3);
        rd(AS, v); check("R2 no-op busy", v, 0);
        repeat (30) @(negedge clk);
        check("R2 no-op edges", nrise - n0, 0);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        wr(AK, 32'd3 << 9);
        wr(AD, 32'h1357);
        wr(AC, (32'd1 << 14) | 32'd6);
        repeat (40) @(negedge clk);
        wr(AK, 32'h0000_7E01);
        rd(AK, v); check("R9 bit reads 1", {63'd0, v[0]}, 1);
        @(negedge clk);
        rd(AK, v); check("R9 defaults restored", v, 32'h4E00);
        rd(AS, v); check("R9 abort busy", v, 0);
        rd(AD, v); check("R9 data cleared", v, 0);
        check("R10 after abort", {mdc, mdio_oe}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_pre();
        t_read();
        t_nopre();
        t_div0();
        t_busy_ignore();
        t_noop();
        t_srst();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end
endmodule